// File: doc/BRIEF.md
# Triple 32-bit Tick Timer Bank

This block holds three independent 32-bit up-counting timers behind a 16-bit register bus. One shared divider turns the input clock into a tick. Each timer counts ticks while its run bit is set, and it compares its count against a 32-bit compare value. On a hit it sets a sticky status bit, and it can restart from zero. Every 32-bit quantity is reached as two 16-bit halves. The compare value takes a new high half only when the low half is written. Reading the low counter half freezes the high half, so the two reads form one coherent value.

Software programs the divider, loads the compare and counter values, and sets the run bit. It then either polls the status bit or enables the timer in the interrupt-enable register so that the single interrupt line goes high. A write of one to the clear bit drops the status.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every control register reads 0, every counter reads 0, every compare half reads 0xFFFF, the divider value reads 0, the interrupt-enable register reads 0 and irq_o is low.
- R2: Timer t sits at byte address t*0x100. Its registers are: control at +0x02, compare high at +0x04, compare low at +0x06, counter high at +0x08 and counter low at +0x0A. The shared page at 0x300 holds the divider value at +0x00 and interrupt enable at +0x02, with bit t for timer t. Read data appears on rdata_o one cycle after the read request, and unmapped addresses read 0.
- R3: With divider value P, a tick occurs once every P+1 clocks. A write to the divider restarts it, so the first tick comes P+1 clocks after that write.
- R4: Control bit 0 (run) makes the counter advance by one per tick. While it is clear, the counter holds its value.
- R5: When the counter equals the compare value on a tick, control bit 2 (status) is set. With control bit 1 clear, the counter keeps incrementing past the match.
- R6: With control bit 1 (restart) set, a match loads the counter with zero instead of incrementing it, which gives a period of compare+1 ticks.
- R7: Status is sticky. Only a control write with bit 3 set clears it, and bit 3 always reads 0. Writing bit 2 has no effect. A match in the same cycle as a clear leaves status set.
- R8: A compare-high write goes into a staging register (reset value 0xFFFF). The staged half and the written low half take effect together when compare-low is written.
- R9: A counter-low read captures the counter's high half into a shadow register. A counter-high read returns that shadow.
- R10: Counter-half writes replace that half directly and take priority over a tick in the same cycle.
- R11: irq_o is high exactly when some timer has both its status bit and its interrupt-enable bit set.
- R12: Register accesses and counting on one timer leave the other timers' counters and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
A wrong count or a wrong match decision shows up at the ports. The bench stops a timer after an exactly known number of clocks and then reads the counter halves and the control word. Any slip of the divider phase or the increment rule changes the count by at least one tick within P+1 clocks. A status bit that is lost, set early or cleared wrongly shows up in the next control read and on irq_o in the cycle after the offending register update. Faults in the staging or shadow logic appear as a stale or premature half on the very next read of that half.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 2 * WORD_W;

  // per-timer register offsets
  localparam logic [7:0] OFF_CTRL   = 8'h02;
  localparam logic [7:0] OFF_CMP_HI = 8'h04;
  localparam logic [7:0] OFF_CMP_LO = 8'h06;
  localparam logic [7:0] OFF_CNT_HI = 8'h08;
  localparam logic [7:0] OFF_CNT_LO = 8'h0A;

  // shared page offsets
  localparam logic [7:0] OFF_PRESCALE = 8'h00;
  localparam logic [7:0] OFF_IRQ_EN   = 8'h02;

  // control bit positions
  localparam int CB_RUN     = 0;
  localparam int CB_RESTART = 1;
  localparam int CB_STAT    = 2;
  localparam int CB_CLR     = 3;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PRE_W-1:0] value_i,
  output logic [PRE_W-1:0] value_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] phase_q;

  assign value_o = div_q;
  assign tick_o  = (phase_q == div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      phase_q <= '0;
    end else if (load_i) begin
      div_q   <= value_i;
      phase_q <= '0;
    end else begin
      phase_q <= tick_o ? '0 : phase_q + 1'b1;
    end
  end

  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_q != '0 && !load_i) |=> !tick_o);

  a_r3_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= div_q);

  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (phase_q == '0));
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tick_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              stat_o
);
  logic              run_q, restart_q, stat_q;
  logic [CNT_W-1:0]  cmp_q, cnt_q, cnt_nxt;
  logic [WORD_W-1:0] stage_q, shadow_q;

  logic hit_ctrl, hit_cmp_hi, hit_cmp_lo, hit_cnt_hi, hit_cnt_lo;
  logic wr_ctrl, wr_cmp_hi, wr_cmp_lo, wr_cnt_hi, wr_cnt_lo, rd_cnt_lo;
  logic step, match, clr;

  assign hit_ctrl   = (off_i == OFF_W'(OFF_CTRL));
  assign hit_cmp_hi = (off_i == OFF_W'(OFF_CMP_HI));
  assign hit_cmp_lo = (off_i == OFF_W'(OFF_CMP_LO));
  assign hit_cnt_hi = (off_i == OFF_W'(OFF_CNT_HI));
  assign hit_cnt_lo = (off_i == OFF_W'(OFF_CNT_LO));

  assign wr_ctrl   = wr_i & hit_ctrl;
  assign wr_cmp_hi = wr_i & hit_cmp_hi;
  assign wr_cmp_lo = wr_i & hit_cmp_lo;
  assign wr_cnt_hi = wr_i & hit_cnt_hi;
  assign wr_cnt_lo = wr_i & hit_cnt_lo;
  assign rd_cnt_lo = rd_i & hit_cnt_lo;

  assign step  = tick_i & run_q;
  assign match = step & (cnt_q == cmp_q);
  assign clr   = wr_ctrl & wdata_i[CB_CLR];

  // bus writes win over counting
  always_comb begin
    cnt_nxt = cnt_q;
    if (wr_cnt_lo)      cnt_nxt = {cnt_q[CNT_W-1:WORD_W], wdata_i};
    else if (wr_cnt_hi) cnt_nxt = {wdata_i, cnt_q[WORD_W-1:0]};
    else if (step)      cnt_nxt = (match && restart_q) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      restart_q <= 1'b0;
      stat_q    <= 1'b0;
      cmp_q     <= '1;
      stage_q   <= '1;
      cnt_q     <= '0;
      shadow_q  <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (match)    stat_q <= 1'b1;
      else if (clr) stat_q <= 1'b0;
      if (wr_ctrl) begin
        run_q     <= wdata_i[CB_RUN];
        restart_q <= wdata_i[CB_RESTART];
      end
      if (wr_cmp_hi) stage_q <= wdata_i;
      if (wr_cmp_lo) cmp_q   <= {stage_q, wdata_i};
      if (rd_cnt_lo) shadow_q <= cnt_q[CNT_W-1:WORD_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o[CB_RUN]     = run_q;
      rdata_o[CB_RESTART] = restart_q;
      rdata_o[CB_STAT]    = stat_q;
    end else if (hit_cmp_hi) rdata_o = cmp_q[CNT_W-1:WORD_W];
    else if (hit_cmp_lo)     rdata_o = cmp_q[WORD_W-1:0];
    else if (hit_cnt_hi)     rdata_o = shadow_q;
    else if (hit_cnt_lo)     rdata_o = cnt_q[WORD_W-1:0];
  end

  assign stat_o = stat_q;

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !clr) |=> stat_q);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !match) |=> !stat_q);

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt_q));

  a_r5_free_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !restart_q && !wr_cnt_lo && !wr_cnt_hi) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && restart_q && !wr_cnt_lo && !wr_cnt_hi) |=> (cnt_q == '0));

  a_r8_staged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp_hi |=> $stable(cmp_q));

  a_r9_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt_lo |=> (shadow_q == $past(cnt_q[CNT_W-1:WORD_W])));
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_pkg::*;
#(
  parameter int N_TIMERS    = 3,
  parameter int ADDR_W      = 12,
  parameter int STRIDE_LOG2 = 8,
  parameter int PRE_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - STRIDE_LOG2;
  localparam int OFF_W = STRIDE_LOG2;

  logic [IDX_W-1:0]  page;
  logic [OFF_W-1:0]  off;
  logic              glb_sel, pre_load, ie_wr, tick;
  logic [PRE_W-1:0]  pre_val;
  logic [N_TIMERS-1:0] ie_q, stat, sel;
  logic [WORD_W-1:0] rd_t [N_TIMERS];
  logic [WORD_W-1:0] rd_mux, rdata_q;

  assign page     = addr_i[ADDR_W-1:STRIDE_LOG2];
  assign off      = addr_i[OFF_W-1:0];
  assign glb_sel  = req_i && (page == IDX_W'(N_TIMERS));
  assign pre_load = glb_sel && we_i && (off == OFF_W'(OFF_PRESCALE));
  assign ie_wr    = glb_sel && we_i && (off == OFF_W'(OFF_IRQ_EN));

  tick_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (pre_load),
    .value_i (wdata_i[PRE_W-1:0]),
    .value_o (pre_val),
    .tick_o  (tick)
  );

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
    assign sel[g] = req_i && (page == IDX_W'(g));
    tick_timer_unit #(.OFF_W(OFF_W)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .wr_i    (sel[g] & we_i),
      .rd_i    (sel[g] & ~we_i),
      .off_i   (off),
      .wdata_i (wdata_i),
      .rdata_o (rd_t[g]),
      .stat_o  (stat[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_TIMERS; i++)
      if (page == IDX_W'(i)) rd_mux = rd_t[i];
    if (page == IDX_W'(N_TIMERS)) begin
      if (off == OFF_W'(OFF_PRESCALE))    rd_mux = WORD_W'(pre_val);
      else if (off == OFF_W'(OFF_IRQ_EN)) rd_mux = WORD_W'(ie_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (ie_wr) ie_q <= wdata_i[N_TIMERS-1:0];
      if (req_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(stat & ie_q);

  a_r2_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  a_r12_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel, glb_sel}));

  a_r11_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat == '0) |-> !irq_o);
endmodule

// File: tb/tick_timer_bank_test.sv
`timescale 1ns/1ps
module tick_timer_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;

  localparam logic [11:0] A_PRE = 12'h300;
  localparam logic [11:0] A_IE  = 12'h302;

  always #2 clk = ~clk;

  tick_timer_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [11:0] ta(input int t, input logic [7:0] o);
    return 12'(t * 256) | {4'h0, o};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk);
    #1 req = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
  endtask

  // stop after a known window, compare counter and control against the model
  task automatic run_case(input int t, input logic [31:0] s, input logic [31:0] c,
                          input bit rst_mode, input int p, input int k, input string tag);
    logic [15:0] lo, hi, ctl;
    logic [31:0] m;
    bit st;
    int n;
    wr(ta(t, 8'h02), 16'h0008);
    wr(ta(t, 8'h08), s[31:16]);
    wr(ta(t, 8'h0A), s[15:0]);
    wr(ta(t, 8'h04), c[31:16]);
    wr(ta(t, 8'h06), c[15:0]);
    wr(A_PRE, 16'(p));
    wr(ta(t, 8'h02), {14'h0, rst_mode, 1'b1});
    idle(k);
    wr(ta(t, 8'h02), {14'h0, rst_mode, 1'b0});
    n = (k + 2) / (p + 1) - ((p == 0) ? 1 : 0);
    m = s; st = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (m == c) begin st = 1'b1; m = rst_mode ? 32'h0 : m + 1; end
      else m = m + 1;
    end
    rd(ta(t, 8'h0A), lo);
    rd(ta(t, 8'h08), hi);
    rd(ta(t, 8'h02), ctl);
    check({tag, " count"}, {hi, lo}, m);
    check({tag, " ctrl/status R7"}, {16'h0, ctl}, {29'h0, st, rst_mode, 1'b0});
  endtask

  initial begin
    #(4 * 200000);
    compared++; mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rd(ta(0, 8'h02), d); check("R1 ctrl", {16'h0, d}, 32'h0);
    rd(ta(2, 8'h04), d); check("R1 cmp hi", {16'h0, d}, 32'hFFFF);
    rd(ta(2, 8'h06), d); check("R1 cmp lo", {16'h0, d}, 32'hFFFF);
    rd(ta(1, 8'h0A), d); check("R1 cnt lo", {16'h0, d}, 32'h0);
    rd(A_PRE, d);        check("R1 prescale", {16'h0, d}, 32'h0);
    rd(A_IE, d);         check("R1 irq enable", {16'h0, d}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R2 unmapped reads and global readback
    rd(12'h30C, d);      check("R2 unmapped global", {16'h0, d}, 32'h0);
    rd(ta(0, 8'h0E), d); check("R2 unmapped timer", {16'h0, d}, 32'h0);
    wr(A_IE, 16'h0005);
    rd(A_IE, d);         check("R2 irq enable readback", {16'h0, d}, 32'h5);
    wr(A_IE, 16'h0000);

    // R8 compare staging
    wr(ta(0, 8'h04), 16'h0001);
    rd(ta(0, 8'h04), d); check("R8 hi not yet applied", {16'h0, d}, 32'hFFFF);
    wr(ta(0, 8'h06), 16'h0002);
    rd(ta(0, 8'h04), d); check("R8 hi applied", {16'h0, d}, 32'h0001);
    rd(ta(0, 8'h06), d); check("R8 lo applied", {16'h0, d}, 32'h0002);

    // R9 / R10 shadow on low read, direct half writes
    wr(ta(1, 8'h08), 16'h1234);
    wr(ta(1, 8'h0A), 16'hABCD);
    rd(ta(1, 8'h0A), d); check("R10 cnt lo write", {16'h0, d}, 32'hABCD);
    wr(ta(1, 8'h08), 16'h5555);
    rd(ta(1, 8'h08), d); check("R9 shadow holds old hi", {16'h0, d}, 32'h1234);
    rd(ta(1, 8'h0A), d);
    rd(ta(1, 8'h08), d); check("R9 shadow refreshed", {16'h0, d}, 32'h5555);

    // R7 writing bit 2 has no effect
    wr(ta(2, 8'h02), 16'h0004);
    rd(ta(2, 8'h02), d); check("R7 status not writable", {16'h0, d}, 32'h0);

    // R4 R5 R6 sweep: compare, window length, mode, timer
    for (int c = 0; c < 6; c++)
      for (int k = 0; k < 8; k++)
        for (int m = 0; m < 2; m++)
          run_case((c + k) % 3, 32'h0, 32'(c), m[0], 0, k, m[0] ? "R6 restart" : "R5 free R4");

    // R3 divider sweep
    for (int p = 1; p < 4; p++)
      for (int k = 0; k < 10; k++)
        run_case(p % 3, 32'h0, 32'hFFFF_FFFF, 1'b0, p, k, "R3 divider");

    // R5 carry across halves with a 32-bit compare
    run_case(0, 32'h0000_FFFE, 32'h0001_0000, 1'b0, 0, 2, "R5 carry");
    run_case(2, 32'h0000_FFFE, 32'h0001_0000, 1'b1, 0, 3, "R6 carry");

    // R12 independence
    wr(ta(1, 8'h02), 16'h0008);
    wr(ta(1, 8'h08), 16'h0000); wr(ta(1, 8'h0A), 16'h0077);
    wr(ta(2, 8'h02), 16'h0008);
    wr(ta(2, 8'h08), 16'h0000); wr(ta(2, 8'h0A), 16'h0099);
    run_case(0, 32'h0, 32'h3, 1'b0, 0, 6, "R12 active timer");
    rd(ta(1, 8'h0A), d); check("R12 timer1 untouched", {16'h0, d}, 32'h77);
    rd(ta(2, 8'h0A), d); check("R12 timer2 untouched", {16'h0, d}, 32'h99);
    rd(ta(1, 8'h02), d); check("R12 timer1 status", {16'h0, d}, 32'h0);

    // R11 interrupt combine and R7 stickiness
    wr(ta(0, 8'h02), 16'h0008);
    run_case(1, 32'h0, 32'h0, 1'b0, 0, 1, "R11 setup");
    #1 check("R11 no enable", {31'h0, irq}, 32'h0);
    wr(A_IE, 16'h0001);
    #1 check("R11 other timer enabled", {31'h0, irq}, 32'h0);
    wr(A_IE, 16'h0002);
    #1 check("R11 enabled", {31'h0, irq}, 32'h1);
    wr(ta(1, 8'h02), 16'h0000);
    #1 check("R7 sticky without clear", {31'h0, irq}, 32'h1);
    wr(ta(1, 8'h02), 16'h0008);
    #1 check("R7 clear drops irq R11", {31'h0, irq}, 32'h0);
    rd(ta(1, 8'h02), d); check("R7 cleared", {16'h0, d}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule